// File: doc/BRIEF.md
# Sixteen-bit ALU with flags

A 16-bit arithmetic and logic unit for a small processor with sixteen general registers. A decoder turns a 5-bit operation code into a control word, and a combinational datapath computes the result from two register operands, two 6-bit immediate fields, an 8-bit byte immediate and the low byte of the current destination value. The block produces the 16-bit result and a write-enable for the register file. A three-bit flag register (zero, overflow, negative) updates on the clock edge that ends a valid operation.

The operations are add and subtract, every two-input bitwise gate with its complement, and a single-source invert. Each gate and arithmetic operation also exists with a zero-extended 6-bit immediate as second operand. There are add and subtract of two immediates, shifts by an immediate amount, high-byte and low-byte loads, and an add that writes only while the zero flag is set. Register index 0 reads as zero and is never written. The register file is outside this block: it supplies the operand values and their indices and takes the result when the write-enable is high.

Top module: `alu16_flagged`

## Requirements
- R1: Codes 0x00 (add) and 0x01 (subtract) give `result` = a + b and a − b modulo 2^16, with `wr_en` high.
- R2: Codes 0x02 and, 0x03 or, 0x04 xor, 0x05 nand, 0x06 nor and 0x07 xnor combine a and b bitwise. Code 0x08 gives the bitwise inverse of a and ignores b.
- R3: Codes 0x0A add, 0x0B subtract, 0x0C and, 0x0D or, 0x0E xor, 0x0F nand, 0x10 nor and 0x11 xnor use `imm_a` zero-extended to 16 bits (0 to 63) in place of b. `b_val` has no effect.
- R4: Codes 0x12 and 0x13 give `imm_a` + `imm_b` and `imm_a` − `imm_b`, each immediate zero-extended, ignoring both register values. They update all three flags like add and subtract.
- R5: Codes 0x14 (left shift), 0x15 (logical right shift) and 0x16 (arithmetic right shift, sign fill) shift a by `imm_a[3:0]`. Bits 5:4 of `imm_a` are ignored.
- R6: Code 0x17 gives {`imm8`, `dst_low`}. Code 0x18 gives `imm8` sign-extended to 16 bits.
- R7: Code 0x09 adds a and b. `wr_en` is high only if `flag_z` is 1 during that cycle. When skipped, the flags are left unchanged.
- R8: An operand whose index (`a_idx`, `b_idx`) is 0 reads as zero, and `dst_low` reads as zero when `d_idx` is 0. `wr_en` is never high when `d_idx` is 0.
- R9: After a valid arithmetic, logic or shift operation, the next clock edge sets `flag_z` to (result == 0) and `flag_n` to result bit 15.
- R10: On add, `flag_v` is set when both operands share a sign and the result's sign differs. On subtract, it is set when the operand signs differ and the result's sign differs from a.
- R11: Logic and shift operations clear `flag_v`. Byte loads (0x17, 0x18) leave all flags unchanged.
- R12: A synchronous active-high `rst` clears all flags. While `op_valid` is low, `wr_en` is low and the flags hold.
- R13: Codes 0x19 to 0x1F are undefined: `wr_en` stays low and the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 5 | Operation select |
| a_idx | input | 4 | Register index of operand a |
| b_idx | input | 4 | Register index of operand b |
| d_idx | input | 4 | Register index of the destination |
| a_val | input | 16 | Value read for operand a |
| b_val | input | 16 | Value read for operand b |
| dst_low | input | 8 | Current low byte of the destination register |
| imm_a | input | 6 | First immediate field, also the shift amount |
| imm_b | input | 6 | Second immediate field |
| imm8 | input | 8 | Byte immediate for the byte loads |
| result | output | 16 | Computed result |
| wr_en | output | 1 | Destination write-enable |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_n | output | 1 | Negative flag |

## Verification
The assertions assume that `op_code` and `op_valid` are settled before each rising edge. The flag checks compare against the `result` seen one edge earlier, so they depend on that. They also assume `rst` is held for at least one edge before the first operation. The bench drives every input at the falling edge, holds reset for two edges before any operation, and reads the flags one time step after the rising edge. Undefined codes and cycles with `op_valid` low are applied on purpose, to show that the flag register holds.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam int DW    = 16;
    localparam int XW    = 4;
    localparam int IMMW  = 6;
    localparam int BYTEW = 8;
    localparam int OPW   = 5;
    localparam int SHW   = $clog2(DW);

    typedef enum logic [OPW-1:0] {
        OP_ADD      = 5'h00, OP_SUB      = 5'h01,
        OP_AND      = 5'h02, OP_OR       = 5'h03, OP_XOR  = 5'h04,
        OP_NAND     = 5'h05, OP_NOR      = 5'h06, OP_XNOR = 5'h07,
        OP_NOT      = 5'h08, OP_ADD_IFZ  = 5'h09,
        OP_ADDI     = 5'h0A, OP_SUBI     = 5'h0B,
        OP_ANDI     = 5'h0C, OP_ORI      = 5'h0D, OP_XORI  = 5'h0E,
        OP_NANDI    = 5'h0F, OP_NORI     = 5'h10, OP_XNORI = 5'h11,
        OP_ADD_2IMM = 5'h12, OP_SUB_2IMM = 5'h13,
        OP_SHL      = 5'h14, OP_SHR      = 5'h15, OP_SHRA  = 5'h16,
        OP_LOAD_HI  = 5'h17, OP_LOAD_LO  = 5'h18
    } op_e;

    typedef enum logic [3:0] {
        K_ADD, K_SUB, K_AND, K_OR, K_XOR,
        K_SHL, K_SHR, K_SHRA, K_LDHI, K_LDLO, K_NONE
    } kind_e;

    typedef enum logic [1:0] {SRC_REG, SRC_IMMA, SRC_IMMB, SRC_ZERO} src_e;
    typedef enum logic [1:0] {FL_ARITH, FL_LOGIC, FL_KEEP} flpol_e;

    typedef struct packed {
        kind_e  kind;
        logic   invert;
        src_e   a_src;
        src_e   b_src;
        flpol_e pol;
        logic   need_z;
        logic   writes;
    } ctl_t;

    typedef struct packed {
        logic z;
        logic v;
        logic n;
    } flags_t;

    function automatic logic [DW-1:0] zext_imm(input logic [IMMW-1:0] i);
        return {{(DW-IMMW){1'b0}}, i};
    endfunction

    function automatic logic add_ovf(input logic [DW-1:0] a, b, r);
        return (a[DW-1] == b[DW-1]) && (r[DW-1] != a[DW-1]);
    endfunction

    function automatic logic sub_ovf(input logic [DW-1:0] a, b, r);
        return (a[DW-1] != b[DW-1]) && (r[DW-1] != a[DW-1]);
    endfunction

    // Port-level classification used only by the checks in the top module.
    function automatic logic code_is_logic(input logic [OPW-1:0] c);
        return (c >= 5'h02 && c <= 5'h08) || (c >= 5'h0C && c <= 5'h11) ||
               (c >= 5'h14 && c <= 5'h16);
    endfunction

    function automatic logic code_sets_flags(input logic [OPW-1:0] c);
        return code_is_logic(c) || c == 5'h00 || c == 5'h01 || c == 5'h0A ||
               c == 5'h0B || c == 5'h12 || c == 5'h13;
    endfunction

endpackage

// File: rtl/alu16_opdec.sv
module alu16_opdec
    import alu16_pkg::*;
(
    input  logic [OPW-1:0] op_code,
    output ctl_t           ctl
);

    function automatic ctl_t mk(input kind_e k, input logic inv, input src_e as,
                                input src_e bs, input flpol_e p, input logic nz);
        ctl_t c;
        c.kind   = k;
        c.invert = inv;
        c.a_src  = as;
        c.b_src  = bs;
        c.pol    = p;
        c.need_z = nz;
        c.writes = 1'b1;
        return c;
    endfunction

    always_comb begin
        case (op_e'(op_code))
            OP_ADD:      ctl = mk(K_ADD,  1'b0, SRC_REG,  SRC_REG,  FL_ARITH, 1'b0);
            OP_SUB:      ctl = mk(K_SUB,  1'b0, SRC_REG,  SRC_REG,  FL_ARITH, 1'b0);
            OP_AND:      ctl = mk(K_AND,  1'b0, SRC_REG,  SRC_REG,  FL_LOGIC, 1'b0);
            OP_OR:       ctl = mk(K_OR,   1'b0, SRC_REG,  SRC_REG,  FL_LOGIC, 1'b0);
            OP_XOR:      ctl = mk(K_XOR,  1'b0, SRC_REG,  SRC_REG,  FL_LOGIC, 1'b0);
            OP_NAND:     ctl = mk(K_AND,  1'b1, SRC_REG,  SRC_REG,  FL_LOGIC, 1'b0);
            OP_NOR:      ctl = mk(K_OR,   1'b1, SRC_REG,  SRC_REG,  FL_LOGIC, 1'b0);
            OP_XNOR:     ctl = mk(K_XOR,  1'b1, SRC_REG,  SRC_REG,  FL_LOGIC, 1'b0);
            OP_NOT:      ctl = mk(K_OR,   1'b1, SRC_REG,  SRC_ZERO, FL_LOGIC, 1'b0);
            OP_ADD_IFZ:  ctl = mk(K_ADD,  1'b0, SRC_REG,  SRC_REG,  FL_ARITH, 1'b1);
            OP_ADDI:     ctl = mk(K_ADD,  1'b0, SRC_REG,  SRC_IMMA, FL_ARITH, 1'b0);
            OP_SUBI:     ctl = mk(K_SUB,  1'b0, SRC_REG,  SRC_IMMA, FL_ARITH, 1'b0);
            OP_ANDI:     ctl = mk(K_AND,  1'b0, SRC_REG,  SRC_IMMA, FL_LOGIC, 1'b0);
            OP_ORI:      ctl = mk(K_OR,   1'b0, SRC_REG,  SRC_IMMA, FL_LOGIC, 1'b0);
            OP_XORI:     ctl = mk(K_XOR,  1'b0, SRC_REG,  SRC_IMMA, FL_LOGIC, 1'b0);
            OP_NANDI:    ctl = mk(K_AND,  1'b1, SRC_REG,  SRC_IMMA, FL_LOGIC, 1'b0);
            OP_NORI:     ctl = mk(K_OR,   1'b1, SRC_REG,  SRC_IMMA, FL_LOGIC, 1'b0);
            OP_XNORI:    ctl = mk(K_XOR,  1'b1, SRC_REG,  SRC_IMMA, FL_LOGIC, 1'b0);
            OP_ADD_2IMM: ctl = mk(K_ADD,  1'b0, SRC_IMMA, SRC_IMMB, FL_ARITH, 1'b0);
            OP_SUB_2IMM: ctl = mk(K_SUB,  1'b0, SRC_IMMA, SRC_IMMB, FL_ARITH, 1'b0);
            OP_SHL:      ctl = mk(K_SHL,  1'b0, SRC_REG,  SRC_ZERO, FL_LOGIC, 1'b0);
            OP_SHR:      ctl = mk(K_SHR,  1'b0, SRC_REG,  SRC_ZERO, FL_LOGIC, 1'b0);
            OP_SHRA:     ctl = mk(K_SHRA, 1'b0, SRC_REG,  SRC_ZERO, FL_LOGIC, 1'b0);
            OP_LOAD_HI:  ctl = mk(K_LDHI, 1'b0, SRC_REG,  SRC_ZERO, FL_KEEP,  1'b0);
            OP_LOAD_LO:  ctl = mk(K_LDLO, 1'b0, SRC_REG,  SRC_ZERO, FL_KEEP,  1'b0);
            default: begin
                ctl        = mk(K_NONE, 1'b0, SRC_REG, SRC_ZERO, FL_KEEP, 1'b0);
                ctl.writes = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu16_datapath.sv
module alu16_datapath
    import alu16_pkg::*;
(
    input  ctl_t             ctl,
    input  logic [DW-1:0]    a_val,
    input  logic [DW-1:0]    b_val,
    input  logic [BYTEW-1:0] dst_low,
    input  logic [IMMW-1:0]  imm_a,
    input  logic [IMMW-1:0]  imm_b,
    input  logic [BYTEW-1:0] imm8,
    output logic [DW-1:0]    result,
    output flags_t           nf
);

    logic [DW-1:0]  op_a, op_b, core, sum, diff;
    logic [SHW-1:0] sh;

    assign op_a = (ctl.a_src == SRC_IMMA) ? zext_imm(imm_a) : a_val;

    always_comb begin
        case (ctl.b_src)
            SRC_REG:  op_b = b_val;
            SRC_IMMA: op_b = zext_imm(imm_a);
            SRC_IMMB: op_b = zext_imm(imm_b);
            default:  op_b = '0;
        endcase
    end

    assign sum  = op_a + op_b;
    assign diff = op_a - op_b;
    assign sh   = imm_a[SHW-1:0];

    always_comb begin
        case (ctl.kind)
            K_ADD:   core = sum;
            K_SUB:   core = diff;
            K_AND:   core = op_a & op_b;
            K_OR:    core = op_a | op_b;
            K_XOR:   core = op_a ^ op_b;
            K_SHL:   core = op_a << sh;
            K_SHR:   core = op_a >> sh;
            K_SHRA:  core = $unsigned($signed(op_a) >>> sh);
            K_LDHI:  core = {imm8, dst_low};
            K_LDLO:  core = {{(DW-BYTEW){imm8[BYTEW-1]}}, imm8};
            default: core = '0;
        endcase
    end

    assign result = ctl.invert ? ~core : core;

    always_comb begin
        nf.z = (result == '0);
        nf.n = result[DW-1];
        case (ctl.kind)
            K_ADD:   nf.v = add_ovf(op_a, op_b, result);
            K_SUB:   nf.v = sub_ovf(op_a, op_b, result);
            default: nf.v = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu16_flagreg.sv
module alu16_flagreg
    import alu16_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  flags_t nxt,
    output flags_t q
);

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= nxt;
    end

    // R12
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));

endmodule

// File: rtl/alu16_flagged.sv
module alu16_flagged
    import alu16_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [OPW-1:0]   op_code,
    input  logic [XW-1:0]    a_idx,
    input  logic [XW-1:0]    b_idx,
    input  logic [XW-1:0]    d_idx,
    input  logic [DW-1:0]    a_val,
    input  logic [DW-1:0]    b_val,
    input  logic [BYTEW-1:0] dst_low,
    input  logic [IMMW-1:0]  imm_a,
    input  logic [IMMW-1:0]  imm_b,
    input  logic [BYTEW-1:0] imm8,
    output logic [DW-1:0]    result,
    output logic             wr_en,
    output logic             flag_z,
    output logic             flag_v,
    output logic             flag_n
);

    ctl_t             ctl;
    flags_t           nf, fq;
    logic [DW-1:0]    a_eff, b_eff;
    logic [BYTEW-1:0] d_eff;
    logic             cond_ok, upd;

    // Register index 0 is the hard-wired zero register.
    assign a_eff = (a_idx == '0) ? '0 : a_val;
    assign b_eff = (b_idx == '0) ? '0 : b_val;
    assign d_eff = (d_idx == '0) ? '0 : dst_low;

    alu16_opdec u_dec (
        .op_code (op_code),
        .ctl     (ctl)
    );

    alu16_datapath u_dp (
        .ctl     (ctl),
        .a_val   (a_eff),
        .b_val   (b_eff),
        .dst_low (d_eff),
        .imm_a   (imm_a),
        .imm_b   (imm_b),
        .imm8    (imm8),
        .result  (result),
        .nf      (nf)
    );

    assign cond_ok = !ctl.need_z || fq.z;
    assign upd     = op_valid && (ctl.pol != FL_KEEP) && cond_ok;
    assign wr_en   = op_valid && ctl.writes && cond_ok && (d_idx != '0);

    alu16_flagreg u_flags (
        .clk  (clk),
        .rst  (rst),
        .load (upd),
        .nxt  (nf),
        .q    (fq)
    );

    assign flag_z = fq.z;
    assign flag_v = fq.v;
    assign flag_n = fq.n;

    // R8
    zero_dest_chk: assert property (@(posedge clk) disable iff (rst)
        (d_idx == '0) |-> !wr_en);

    // R7
    ifz_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_ADD_IFZ && !flag_z) |-> !wr_en);

    // R11
    logic_v_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && code_is_logic(op_code)) |=> !flag_v);

    // R11
    load_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == OP_LOAD_HI || op_code == OP_LOAD_LO))
        |=> $stable({flag_z, flag_v, flag_n}));

    // R9
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && code_sets_flags(op_code))
        |=> (flag_z == ($past(result) == '0)) && (flag_n == $past(result[DW-1])));

    // R13
    undef_code_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code > OP_LOAD_LO)
        |=> $stable({flag_z, flag_v, flag_n}) && !$past(wr_en));

endmodule

// File: tb/alu16_flagged_test.sv
module alu16_flagged_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [4:0]  op_code = '0;
    logic [3:0]  a_idx = 4'd1, b_idx = 4'd2, d_idx = 4'd3;
    logic [15:0] a_val = '0, b_val = '0;
    logic [7:0]  dst_low = '0;
    logic [5:0]  imm_a = '0, imm_b = '0;
    logic [7:0]  imm8 = '0;
    logic [15:0] result;
    logic        wr_en, flag_z, flag_v, flag_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [15:0] got_res;
    logic        got_wr;

    always #5 clk = ~clk;

    alu16_flagged uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .a_idx(a_idx), .b_idx(b_idx), .d_idx(d_idx),
        .a_val(a_val), .b_val(b_val), .dst_low(dst_low),
        .imm_a(imm_a), .imm_b(imm_b), .imm8(imm8),
        .result(result), .wr_en(wr_en),
        .flag_z(flag_z), .flag_v(flag_v), .flag_n(flag_n)
    );

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic chk_flags(input string tag, input logic z, input logic v, input logic n);
        check(tag, "flags zvn", {13'b0, flag_z, flag_v, flag_n}, {13'b0, z, v, n});
    endtask

    // Drive at the falling edge, capture combinational outputs, then let the edge pass.
    task automatic apply(input logic [4:0] op, input logic [15:0] av, input logic [15:0] bv,
                         input logic [5:0] ia, input logic [5:0] ib, input logic [7:0] i8,
                         input logic [7:0] dl);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; a_val = av; b_val = bv;
        imm_a = ia; imm_b = ib; imm8 = i8; dst_low = dl;
        #1;
        got_res = result;
        got_wr  = wr_en;
        @(posedge clk);
        #1;
    endtask

    task automatic op_res(input string tag, input logic [4:0] op, input logic [15:0] av,
                          input logic [15:0] bv, input logic [5:0] ia, input logic [5:0] ib,
                          input logic [15:0] exp);
        apply(op, av, bv, ia, ib, 8'h00, 8'h00);
        check(tag, "result", got_res, exp);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R12 reset state
        chk_flags("R12", 1'b0, 1'b0, 1'b0);
        check("R12", "wr_en idle", {15'b0, wr_en}, 16'h0);
    endtask

    task automatic t_arith;
        op_res("R1", 5'h00, 16'h1234, 16'h1111, 0, 0, 16'h2345);
        check("R1", "wr_en", {15'b0, got_wr}, 16'h1);
        chk_flags("R9", 1'b0, 1'b0, 1'b0);
        op_res("R10", 5'h00, 16'h7FFF, 16'h0001, 0, 0, 16'h8000);
        chk_flags("R10", 1'b0, 1'b1, 1'b1);
        op_res("R10", 5'h01, 16'h8000, 16'h0001, 0, 0, 16'h7FFF);
        chk_flags("R10", 1'b0, 1'b1, 1'b0);
        op_res("R1", 5'h01, 16'h0005, 16'h0005, 0, 0, 16'h0000);
        chk_flags("R9", 1'b1, 1'b0, 1'b0);
        op_res("R10", 5'h00, 16'hFFFF, 16'h0001, 0, 0, 16'h0000);
        chk_flags("R10", 1'b1, 1'b0, 1'b0);
        op_res("R10", 5'h01, 16'h0000, 16'h8000, 0, 0, 16'h8000);
        chk_flags("R10", 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_gates;
        op_res("R2", 5'h02, 16'hF0F0, 16'hFF00, 0, 0, 16'hF000);
        chk_flags("R11", 1'b0, 1'b0, 1'b1);
        op_res("R2", 5'h05, 16'hF0F0, 16'hFF00, 0, 0, 16'h0FFF);
        op_res("R2", 5'h03, 16'hF0F0, 16'h0F00, 0, 0, 16'hFFF0);
        op_res("R2", 5'h06, 16'hF0F0, 16'h0F0F, 0, 0, 16'h0000);
        chk_flags("R9", 1'b1, 1'b0, 1'b0);
        op_res("R2", 5'h04, 16'hF0F0, 16'hFF00, 0, 0, 16'h0FF0);
        op_res("R2", 5'h07, 16'hF0F0, 16'hFF00, 0, 0, 16'hF00F);
        op_res("R2", 5'h08, 16'h1234, 16'hFFFF, 0, 0, 16'hEDCB);
        chk_flags("R9", 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_imm;
        op_res("R3", 5'h0A, 16'h0010, 16'hAAAA, 6'h3F, 0, 16'h004F);
        op_res("R3", 5'h0B, 16'h0000, 16'hAAAA, 6'h01, 0, 16'hFFFF);
        chk_flags("R3", 1'b0, 1'b0, 1'b1);
        op_res("R3", 5'h0C, 16'hFFFF, 16'hAAAA, 6'h2A, 0, 16'h002A);
        op_res("R3", 5'h0D, 16'h1200, 16'hAAAA, 6'h3F, 0, 16'h123F);
        op_res("R3", 5'h0E, 16'hFFFF, 16'hAAAA, 6'h3F, 0, 16'hFFC0);
        op_res("R3", 5'h0F, 16'hFFFF, 16'hAAAA, 6'h3F, 0, 16'hFFC0);
        op_res("R3", 5'h10, 16'h0000, 16'hAAAA, 6'h3F, 0, 16'hFFC0);
        op_res("R3", 5'h11, 16'h00FF, 16'hAAAA, 6'h0F, 0, 16'hFF0F);
        op_res("R3", 5'h0A, 16'h7FFF, 16'hAAAA, 6'h01, 0, 16'h8000);
        chk_flags("R10", 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_2imm;
        op_res("R4", 5'h12, 16'hAAAA, 16'h5555, 6'h3F, 6'h3F, 16'h007E);
        chk_flags("R4", 1'b0, 1'b0, 1'b0);
        op_res("R4", 5'h13, 16'hAAAA, 16'h5555, 6'h00, 6'h3F, 16'hFFC1);
        chk_flags("R4", 1'b0, 1'b0, 1'b1);
        op_res("R4", 5'h13, 16'hAAAA, 16'h5555, 6'h05, 6'h05, 16'h0000);
        chk_flags("R4", 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_shift;
        op_res("R5", 5'h14, 16'h0001, 16'h0000, 6'h11, 0, 16'h0002);
        op_res("R5", 5'h15, 16'h8000, 16'h0000, 6'h04, 0, 16'h0800);
        op_res("R5", 5'h16, 16'h8000, 16'h0000, 6'h04, 0, 16'hF800);
        chk_flags("R5", 1'b0, 1'b0, 1'b1);
        op_res("R5", 5'h16, 16'h4000, 16'h0000, 6'h0F, 0, 16'h0000);
        chk_flags("R9", 1'b1, 1'b0, 1'b0);
        op_res("R5", 5'h14, 16'hFFFF, 16'h0000, 6'h20, 0, 16'hFFFF);
        op_res("R5", 5'h16, 16'h7FF0, 16'h0000, 6'h04, 0, 16'h07FF);
    endtask

    task automatic t_loads;
        op_res("R10", 5'h01, 16'h8000, 16'h0001, 0, 0, 16'h7FFF);
        apply(5'h17, 16'h0000, 16'h0000, 0, 0, 8'hAB, 8'h34);
        check("R6", "load high", got_res, 16'hAB34);
        check("R6", "wr_en", {15'b0, got_wr}, 16'h1);
        chk_flags("R11", 1'b0, 1'b1, 1'b0);
        apply(5'h18, 16'h0000, 16'h0000, 0, 0, 8'h80, 8'h00);
        check("R6", "load low neg", got_res, 16'hFF80);
        chk_flags("R11", 1'b0, 1'b1, 1'b0);
        apply(5'h18, 16'h0000, 16'h0000, 0, 0, 8'h7F, 8'h00);
        check("R6", "load low pos", got_res, 16'h007F);
    endtask

    task automatic t_ifz;
        op_res("R7", 5'h01, 16'h0005, 16'h0005, 0, 0, 16'h0000);
        op_res("R7", 5'h09, 16'h0003, 16'h0004, 0, 0, 16'h0007);
        check("R7", "taken wr_en", {15'b0, got_wr}, 16'h1);
        chk_flags("R7", 1'b0, 1'b0, 1'b0);
        apply(5'h09, 16'h0003, 16'h0004, 0, 0, 8'h00, 8'h00);
        check("R7", "skipped wr_en", {15'b0, got_wr}, 16'h0);
        op_res("R7", 5'h01, 16'h8000, 16'h0001, 0, 0, 16'h7FFF);
        apply(5'h09, 16'hFFFF, 16'h0001, 0, 0, 8'h00, 8'h00);
        check("R7", "skipped wr_en", {15'b0, got_wr}, 16'h0);
        chk_flags("R7", 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_zero_reg;
        a_idx = 4'd0;
        op_res("R8", 5'h00, 16'h5555, 16'h0001, 0, 0, 16'h0001);
        a_idx = 4'd1; b_idx = 4'd0;
        op_res("R8", 5'h01, 16'h0009, 16'h1234, 0, 0, 16'h0009);
        b_idx = 4'd2; d_idx = 4'd0;
        op_res("R8", 5'h00, 16'h0001, 16'h0001, 0, 0, 16'h0002);
        check("R8", "wr_en dest 0", {15'b0, got_wr}, 16'h0);
        apply(5'h17, 16'h0000, 16'h0000, 0, 0, 8'hAB, 8'h34);
        check("R8", "load high dest 0", got_res, 16'hAB00);
        check("R8", "wr_en dest 0", {15'b0, got_wr}, 16'h0);
        d_idx = 4'd3;
    endtask

    task automatic t_idle;
        op_res("R12", 5'h01, 16'h0005, 16'h0005, 0, 0, 16'h0000);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            op_valid = 1'b0; op_code = 5'h00; a_val = 16'h0001; b_val = 16'h0001;
            #1;
            check("R12", "wr_en idle", {15'b0, wr_en}, 16'h0);
            @(posedge clk);
            #1;
            chk_flags("R12", 1'b1, 1'b0, 1'b0);
        end
    endtask

    task automatic t_undef;
        apply(5'h1B, 16'h7FFF, 16'h0001, 0, 0, 8'h00, 8'h00);
        check("R13", "wr_en", {15'b0, got_wr}, 16'h0);
        chk_flags("R13", 1'b1, 1'b0, 1'b0);
        apply(5'h1F, 16'h0001, 16'h0001, 0, 0, 8'h00, 8'h00);
        check("R13", "wr_en", {15'b0, got_wr}, 16'h0);
        chk_flags("R13", 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_reset_mid;
        op_res("R12", 5'h00, 16'h7FFF, 16'h0001, 0, 0, 16'h8000);
        @(negedge clk);
        op_valid = 1'b0; rst = 1'b1;
        @(posedge clk);
        #1;
        chk_flags("R12", 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        t_reset();
        t_arith();
        t_gates();
        t_imm();
        t_2imm();
        t_shift();
        t_loads();
        t_ifz();
        t_zero_reg();
        t_idle();
        t_undef();
        t_reset_mid();
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule